// File: doc/BRIEF.md
# Watchdog Register Unlock Front End

This block sits between a memory-mapped bus and a watchdog timer core. It guards the two countdown preload values and the control actions (kick and flag clear) behind a two-step key sequence. Software must first write the value 0x80 and then the value 0x86 to the control offset. Only after that does one protected access get through. Every halfword or word write made after the sequence is complete uses up the unlock, whether or not it reaches a protected register.

The window is 16 bytes wide and the bus gives each access a size code: 0 for a byte, 1 for a halfword, 2 for a word, with 3 treated as no access. Accepted updates reach the timer core as one-cycle strobes that are registered on the write cycle. The first-phase and second-phase preload strobes share one 20-bit value bus. Reads return the previous-reboot flag on two bit positions at once: bits 9 and 12, giving 0x1200. Read data is registered and appears on the cycle after the read is issued. Reset is synchronous and active high.

Top module: `wdt_unlock_front`

## Requirements
- R1: After reset, and after any reset pulse, the lock state is idle and the outputs are quiet. A protected write issued without a fresh key sequence has no effect. All strobes are 0 and rdata is 0.
- R2: A write of 0x80 to offset 0xC moves the lock to the armed state. The data is taken at the access size, and this applies at any size and from any lock state.
- R3: A write of 0x86 to offset 0xC opens the lock only from the armed state. A 0x86 write with no 0x80 before it opens nothing.
- R4: While the lock is open, a word write to offset 0x0 pulses phase1_load and a word write to offset 0x4 pulses phase2_load. In both cases preload_value carries the low 20 bits of wdata.
- R5: While the lock is open, a halfword write to offset 0xC does two things. It pulses kick if bit 8 is set, and it pulses reboot_flag_clear if bit 9 or bit 12 is set.
- R6: While the lock is open, any halfword or word write that is not 0x80 to offset 0xC returns the lock to idle. This includes writes to unprotected offsets, halfword writes to 0x0 or 0x4, and word writes to 0xC, none of which produce a strobe.
- R7: Byte writes never produce a strobe. A byte write that is not the 0x80 key leaves an open lock open.
- R8: In the armed state, any write other than 0x80 or 0x86 to offset 0xC leaves the lock armed.
- R9: A halfword read of offset 0xC returns 0x1200 on rdata in the next cycle when prev_reboot_flag is 1, and 0 when it is 0. Every other read returns 0.
- R10: Strobes are single-cycle pulses, high in the cycle after the write, and at most one strobe of the two preload loads and kick is high at a time.
- R11: Without an unlock, word writes to offsets 0x0 and 0x4 and halfword writes to 0xC produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| addr | input | ADDR_W (4) | Byte offset within the 16-byte window |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 none |
| wdata | input | DATA_W (32) | Write data, least significant bits used for narrow sizes |
| rdata | output | DATA_W (32) | Registered read data |
| prev_reboot_flag | input | 1 | Previous-reboot flag held by the timer core |
| phase1_load | output | 1 | Pulse: load first-phase preload |
| phase2_load | output | 1 | Pulse: load second-phase preload |
| preload_value | output | PRELOAD_W (20) | Preload value for the pulsed load |
| kick | output | 1 | Pulse: restart the countdown |
| reboot_flag_clear | output | 1 | Pulse: clear the previous-reboot flag |

## Verification
The lock state cannot be read, so a corrupted state only becomes visible through the next protected write. A lock that opens too easily emits a strobe one cycle after a write that should have done nothing. A lock that fails to open, or that stays open too long, shows as a missing strobe, or as an extra strobe on the write that follows. Each scenario therefore ends with a probing write whose strobe pattern, sampled one cycle later, shows which state the lock was really in.

// File: rtl/wdt_unlock_pkg.sv
package wdt_unlock_pkg;

    localparam int ADDR_W_DEF    = 4;
    localparam int DATA_W_DEF    = 32;
    localparam int PRELOAD_W_DEF = 20;

    // bus access size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // offsets inside the window
    localparam logic [7:0] OFS_PHASE1 = 8'h00;
    localparam logic [7:0] OFS_PHASE2 = 8'h04;
    localparam logic [7:0] OFS_CTL    = 8'h0C;

    // key values and control bits
    localparam logic [15:0] KEY_FIRST   = 16'h0080;
    localparam logic [15:0] KEY_SECOND  = 16'h0086;
    localparam int          BIT_KICK    = 8;
    localparam int          BIT_CLR_LO  = 9;
    localparam int          BIT_CLR_HI  = 12;
    localparam logic [31:0] FLAG_RVALUE = 32'h0000_1200;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_ARMED = 2'd1,
        LK_OPEN  = 2'd2
    } lock_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic byte_sz;
        logic half_sz;
        logic word_sz;
        logic at_p1;
        logic at_p2;
        logic at_ctl;
        logic key_first;
        logic key_second;
    } access_t;

    typedef struct packed {
        logic p1;
        logic p2;
        logic kick;
        logic clr;
    } strobe_t;

endpackage

// File: rtl/wdt_access_decode.sv
module wdt_access_decode
    import wdt_unlock_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output access_t           acc
);
    localparam int HALF_W = (DATA_W < 16) ? DATA_W : 16;

    logic [DATA_W-1:0] masked;
    logic              any_sz;

    always_comb begin
        masked = '0;
        unique case (size)
            SZ_BYTE: masked[7:0]        = wdata[7:0];
            SZ_HALF: masked[HALF_W-1:0] = wdata[HALF_W-1:0];
            SZ_WORD: masked             = wdata;
            default: masked             = '0;
        endcase
    end

    assign any_sz = (size == SZ_BYTE) || (size == SZ_HALF) || (size == SZ_WORD);

    always_comb begin
        acc            = '0;
        acc.wr         = wr_en && any_sz;
        acc.rd         = rd_en && any_sz;
        acc.byte_sz    = (size == SZ_BYTE);
        acc.half_sz    = (size == SZ_HALF);
        acc.word_sz    = (size == SZ_WORD);
        acc.at_p1      = (addr == OFS_PHASE1[ADDR_W-1:0]);
        acc.at_p2      = (addr == OFS_PHASE2[ADDR_W-1:0]);
        acc.at_ctl     = (addr == OFS_CTL[ADDR_W-1:0]);
        acc.key_first  = acc.at_ctl && (masked == DATA_W'(KEY_FIRST));
        acc.key_second = acc.at_ctl && (masked == DATA_W'(KEY_SECOND));
    end

endmodule

// File: rtl/wdt_lock_fsm.sv
module wdt_lock_fsm
    import wdt_unlock_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    output lock_e   state,
    output logic    take
);
    lock_e nxt;

    always_comb begin
        nxt  = state;
        take = 1'b0;
        if (acc.wr) begin
            if (acc.key_first) begin
                nxt = LK_ARMED;
            end else if (acc.key_second && state == LK_ARMED) begin
                nxt = LK_OPEN;
            end else if (state == LK_OPEN && !acc.byte_sz) begin
                take = 1'b1;
                nxt  = LK_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LK_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/wdt_action_gen.sv
module wdt_action_gen
    import wdt_unlock_pkg::*;
#(
    parameter int DATA_W    = DATA_W_DEF,
    parameter int PRELOAD_W = PRELOAD_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  access_t              acc,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 take,
    input  logic                 flag_in,
    output strobe_t              strobes,
    output logic [PRELOAD_W-1:0] preload,
    output logic [DATA_W-1:0]    rdata
);
    strobe_t           stb_d;
    logic [DATA_W-1:0] rdata_d;
    logic              ctl_half;

    assign ctl_half = take && acc.half_sz && acc.at_ctl;

    always_comb begin
        stb_d      = '0;
        stb_d.p1   = take && acc.word_sz && acc.at_p1;
        stb_d.p2   = take && acc.word_sz && acc.at_p2;
        stb_d.kick = ctl_half && wdata[BIT_KICK];
        stb_d.clr  = ctl_half && (wdata[BIT_CLR_LO] || wdata[BIT_CLR_HI]);
    end

    always_comb begin
        rdata_d = '0;
        if (acc.rd && acc.half_sz && acc.at_ctl && flag_in)
            rdata_d = DATA_W'(FLAG_RVALUE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobes <= '0;
            preload <= '0;
            rdata   <= '0;
        end else begin
            strobes <= stb_d;
            rdata   <= rdata_d;
            if (stb_d.p1 || stb_d.p2)
                preload <= wdata[PRELOAD_W-1:0];
        end
    end

endmodule

// File: rtl/wdt_unlock_front.sv
module wdt_unlock_front
    import wdt_unlock_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int PRELOAD_W = PRELOAD_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [1:0]           size,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic                 prev_reboot_flag,
    output logic                 phase1_load,
    output logic                 phase2_load,
    output logic [PRELOAD_W-1:0] preload_value,
    output logic                 kick,
    output logic                 reboot_flag_clear
);
    access_t acc;
    lock_e   lock_state;
    logic    take;
    strobe_t strobes;

    wdt_access_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .size  (size),
        .wdata (wdata),
        .acc   (acc)
    );

    wdt_lock_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .state (lock_state),
        .take  (take)
    );

    wdt_action_gen #(.DATA_W(DATA_W), .PRELOAD_W(PRELOAD_W)) u_action (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wdata   (wdata),
        .take    (take),
        .flag_in (prev_reboot_flag),
        .strobes (strobes),
        .preload (preload_value),
        .rdata   (rdata)
    );

    assign phase1_load       = strobes.p1;
    assign phase2_load       = strobes.p2;
    assign kick              = strobes.kick;
    assign reboot_flag_clear = strobes.clr;

endmodule

// File: rtl/wdt_unlock_front_chk.sv
module wdt_unlock_front_chk #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int PRELOAD_W = 20
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [1:0]           size,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    rdata,
    input logic                 prev_reboot_flag,
    input logic                 phase1_load,
    input logic                 phase2_load,
    input logic [PRELOAD_W-1:0] preload_value,
    input logic                 kick,
    input logic                 reboot_flag_clear,
    input logic [1:0]           lock_state
);
    localparam logic [1:0] S_IDLE  = 2'd0;
    localparam logic [1:0] S_ARMED = 2'd1;
    localparam logic [1:0] S_OPEN  = 2'd2;

    logic at_c, at_0, k80, k86, any_stb;

    assign at_c = (addr == ADDR_W'(12));
    assign at_0 = (addr == ADDR_W'(0));
    always_comb begin
        k80 = 1'b0;
        k86 = 1'b0;
        if (wr_en && at_c) begin
            case (size)
                2'd0: begin k80 = wdata[7:0] == 8'h80;   k86 = wdata[7:0] == 8'h86; end
                2'd1: begin k80 = wdata[15:0] == 16'h80; k86 = wdata[15:0] == 16'h86; end
                2'd2: begin k80 = wdata == DATA_W'(32'h80); k86 = wdata == DATA_W'(32'h86); end
                default: begin k80 = 1'b0; k86 = 1'b0; end
            endcase
        end
    end
    assign any_stb = phase1_load || phase2_load || kick || reboot_flag_clear;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lock_state == S_IDLE && !any_stb && rdata == '0));

    a_r2_key_arms: assert property (@(posedge clk) disable iff (rst)
        k80 |=> lock_state == S_ARMED);

    a_r3_no_skip: assert property (@(posedge clk) disable iff (rst)
        lock_state == S_IDLE |=> lock_state != S_OPEN);

    a_r4_phase1_source: assert property (@(posedge clk) disable iff (rst)
        phase1_load |-> $past(wr_en && size == 2'd2 && at_0 && lock_state == S_OPEN));

    a_r5_kick_source: assert property (@(posedge clk) disable iff (rst)
        kick |-> $past(wr_en && size == 2'd1 && at_c && wdata[8] && lock_state == S_OPEN));

    a_r6_consumed: assert property (@(posedge clk) disable iff (rst)
        (lock_state == S_OPEN && wr_en && (size == 2'd1 || size == 2'd2) && !k80)
        |=> lock_state == S_IDLE);

    a_r7_byte_harmless: assert property (@(posedge clk) disable iff (rst)
        (lock_state == S_OPEN && wr_en && size == 2'd0 && !k80)
        |=> (lock_state == S_OPEN && !any_stb));

    a_r8_armed_holds: assert property (@(posedge clk) disable iff (rst)
        (lock_state == S_ARMED && !k80 && !k86) |=> lock_state == S_ARMED);

    a_r9_read_value: assert property (@(posedge clk) disable iff (rst)
        (rdata != '0) |-> (rdata == DATA_W'(32'h1200)
            && $past(rd_en && size == 2'd1 && at_c && prev_reboot_flag)));

    a_r10_one_hot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({phase1_load, phase2_load, kick}));

    a_r10_kick_pulse: assert property (@(posedge clk) disable iff (rst)
        kick |=> !kick);

endmodule

bind wdt_unlock_front wdt_unlock_front_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRELOAD_W(PRELOAD_W)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .wr_en             (wr_en),
    .rd_en             (rd_en),
    .addr              (addr),
    .size              (size),
    .wdata             (wdata),
    .rdata             (rdata),
    .prev_reboot_flag  (prev_reboot_flag),
    .phase1_load       (phase1_load),
    .phase2_load       (phase2_load),
    .preload_value     (preload_value),
    .kick              (kick),
    .reboot_flag_clear (reboot_flag_clear),
    .lock_state        (lock_state)
);

// File: tb/test_wdt_unlock_front.sv
module test_wdt_unlock_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        prev_reboot_flag = 1'b0;
    logic        phase1_load, phase2_load, kick, reboot_flag_clear;
    logic [19:0] preload_value;

    int errors = 0;
    int checks = 0;

    // captured strobes {p1,p2,kick,clr}
    logic [3:0]  cap_stb;
    logic [19:0] cap_val;
    logic [31:0] cap_rd;

    always #5 clk = ~clk;

    wdt_unlock_front i_wdt_unlock_front (
        .clk               (clk),
        .rst               (rst),
        .wr_en             (wr_en),
        .rd_en             (rd_en),
        .addr              (addr),
        .size              (size),
        .wdata             (wdata),
        .rdata             (rdata),
        .prev_reboot_flag  (prev_reboot_flag),
        .phase1_load       (phase1_load),
        .phase2_load       (phase2_load),
        .preload_value     (preload_value),
        .kick              (kick),
        .reboot_flag_clear (reboot_flag_clear)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one bus write; strobes sampled one cycle later
    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; size = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        cap_stb = {phase1_load, phase2_load, kick, reboot_flag_clear};
        cap_val = preload_value;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s);
        @(negedge clk);
        rd_en = 1'b1; addr = a; size = s;
        @(negedge clk);
        rd_en = 1'b0;
        cap_rd = rdata;
    endtask

    task automatic unlock();
        wr(4'hC, 2'd1, 32'h80);
        wr(4'hC, 2'd1, 32'h86);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset strobes", {28'd0, phase1_load, phase2_load, kick, reboot_flag_clear}, 32'd0);
        check("R1 reset rdata", rdata, 32'd0);
    endtask

    task automatic t_no_unlock();
        wr(4'h0, 2'd2, 32'h1234);
        check("R11 phase1 without unlock", {28'd0, cap_stb}, 32'd0);
        wr(4'hC, 2'd1, 32'h0100);
        check("R11 kick without unlock", {28'd0, cap_stb}, 32'd0);
        wr(4'hC, 2'd2, 32'h86);
        wr(4'h4, 2'd2, 32'h77);
        check("R3 second key alone opens nothing", {28'd0, cap_stb}, 32'd0);
    endtask

    task automatic t_preload1();
        wr(4'hC, 2'd0, 32'h80);   // byte key
        wr(4'hC, 2'd2, 32'h86);   // word key
        wr(4'h0, 2'd2, 32'hABC1_2345);
        check("R2 R4 phase1 strobe", {28'd0, cap_stb}, 32'h8);
        check("R4 phase1 value low 20 bits", {12'd0, cap_val}, 32'h12345);
        @(negedge clk);
        check("R10 strobe lasts one cycle", {28'd0, phase1_load, phase2_load, kick, reboot_flag_clear}, 32'd0);
    endtask

    task automatic t_preload2();
        unlock();
        wr(4'h4, 2'd2, 32'hFFFF_FFFF);
        check("R4 phase2 strobe", {28'd0, cap_stb}, 32'h4);
        check("R4 phase2 value", {12'd0, cap_val}, 32'hFFFFF);
    endtask

    task automatic t_kick_clear();
        unlock();
        wr(4'hC, 2'd1, 32'h0100);
        check("R5 kick only", {28'd0, cap_stb}, 32'h2);
        unlock();
        wr(4'hC, 2'd1, 32'h1000);
        check("R5 clear via bit 12", {28'd0, cap_stb}, 32'h1);
        unlock();
        wr(4'hC, 2'd1, 32'h0300);
        check("R5 kick and clear via bit 9", {28'd0, cap_stb}, 32'h3);
    endtask

    task automatic t_consume();
        unlock();
        wr(4'h8, 2'd2, 32'h5);
        check("R6 unprotected write no strobe", {28'd0, cap_stb}, 32'd0);
        wr(4'h0, 2'd2, 32'h11);
        check("R6 unlock used up", {28'd0, cap_stb}, 32'd0);
        unlock();
        wr(4'h0, 2'd1, 32'h22);
        check("R6 halfword to preload ignored", {28'd0, cap_stb}, 32'd0);
        unlock();
        wr(4'hC, 2'd2, 32'h0100);
        check("R6 word to control ignored", {28'd0, cap_stb}, 32'd0);
        wr(4'hC, 2'd1, 32'h0100);
        check("R6 lock idle after word to control", {28'd0, cap_stb}, 32'd0);
    endtask

    task automatic t_byte();
        unlock();
        wr(4'hC, 2'd0, 32'h01);
        check("R7 byte to control no strobe", {28'd0, cap_stb}, 32'd0);
        wr(4'h0, 2'd0, 32'h33);
        check("R7 byte to preload no strobe", {28'd0, cap_stb}, 32'd0);
        wr(4'hC, 2'd1, 32'h0100);
        check("R7 lock still open after bytes", {28'd0, cap_stb}, 32'h2);
    endtask

    task automatic t_armed_hold();
        wr(4'hC, 2'd2, 32'h80);
        wr(4'h8, 2'd2, 32'h5);
        wr(4'hC, 2'd1, 32'h0100);
        check("R8 non-key write in armed no strobe", {28'd0, cap_stb}, 32'd0);
        wr(4'hC, 2'd2, 32'h86);
        wr(4'h4, 2'd2, 32'h7);
        check("R8 still armed then opened", {28'd0, cap_stb}, 32'h4);
    endtask

    task automatic t_read();
        prev_reboot_flag = 1'b1;
        rd(4'hC, 2'd1);
        check("R9 flag read set", cap_rd, 32'h1200);
        rd(4'hC, 2'd2);
        check("R9 word read zero", cap_rd, 32'h0);
        rd(4'h8, 2'd1);
        check("R9 other offset zero", cap_rd, 32'h0);
        prev_reboot_flag = 1'b0;
        rd(4'hC, 2'd1);
        check("R9 flag read clear", cap_rd, 32'h0);
    endtask

    task automatic t_reset_mid();
        unlock();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wr(4'h0, 2'd2, 32'h9);
        check("R1 reset drops unlock", {28'd0, cap_stb}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_no_unlock();
        t_preload1();
        t_preload2();
        t_kick_clear();
        t_consume();
        t_byte();
        t_armed_hold();
        t_read();
        t_reset_mid();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

endmodule